// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block sits behind the serial command decoder of a three-wire serial memory. It owns the write-enable latch and runs the self-timed cycles that change the memory array. There are four such cycles: a single-word write that clears the word before it stores it, a single-word erase, an erase of the whole array, and a write of one word into every location. The decoder hands over each decoded command as a one-clock strobe with its opcode, address and data word. The block arms a program-type command and starts it only when chip select falls before the next serial-clock rising edge. It then drives the array write port for a fixed number of clocks and holds the busy flag for that time.

While a cycle runs, and after it ends, raising chip select puts the status on the data-out pin: low while busy, high when ready. Shifting a 1 into the data input hides that status again. The serial clock, chip select and data input arrive already synchronised to `clk`. Edges of these signals are found by comparing each one with its value in the previous clock.

The command input is a strobe with no back-pressure. A strobe that arrives while a cycle runs is dropped, and the decoder is expected to poll the status before it sends the next command. The array port is a write-only valid stream that cannot stall. Every word is presented for exactly one clock.

Top module: `prog_cycle_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, the enable latch is clear, `busy` is 0, `do_oe` is 0 and `mem_we` is 0.
- R2: With the latch clear, commands with `cmd_op` 1 (write), 2 (erase), 3 (erase all) or 4 (write all) cause no array write and no busy period.
- R3: `cmd_op` 5 sets the enable latch. It stays set across any number of cycles until `cmd_op` 6 or a reset clears it.
- R4: An accepted program command starts its cycle only if `cs` falls before the next rising edge of `sk`. If `sk` rises first, the command is dropped.
- R5: `busy` rises one clock after `cs` falls and stays high for exactly `CYCLE_CLKS` clocks, with `sk` idle.
- R6: A write produces two array writes to its address in the first two busy clocks: first all ones, then the data word.
- R7: An erase produces one array write of all ones to its address, in the first busy clock.
- R8: Write all writes the data word to every address in ascending order from 0, one per clock from the first busy clock. Erase all does the same with all ones.
- R9: After a cycle has started, `do_oe` follows `cs`. While `cs` is high, `do_out` is 0 while busy and 1 when ready.
- R10: If `di` is 1 on an `sk` rising edge while the status is shown, `do_oe` drops after the next `sk` falling edge.
- R11: Every command strobe that arrives while `busy` is high is ignored, including enable, disable and program commands.
- R12: `cmd_op` 0 (read) changes neither the latch nor the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | One-clock strobe for a decoded command |
| cmd_op | input | 3 | Opcode: 0 read, 1 write, 2 erase, 3 erase all, 4 write all, 5 enable, 6 disable |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of a write or write all |
| cs | input | 1 | Chip select, synchronised |
| sk | input | 1 | Serial clock, synchronised |
| di | input | 1 | Serial data in, synchronised |
| mem_we | output | 1 | Array write valid, one word per clock |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| do_out | output | 1 | Status bit on data out: 0 busy, 1 ready |
| do_oe | output | 1 | Output enable of data out |
| busy | output | 1 | High while a self-timed cycle runs |

## Verification
The bench builds the block with its default parameters: a 16-word array of 16-bit words and a 40-clock cycle. A small array lets the scoreboard follow both whole-array sweeps address by address within a few hundred clocks. A cycle well longer than the array size leaves room to poll the status during the busy period and to send commands that must be dropped. Timing edge cases in the window after the last bit are driven explicitly: an `sk` rise before `cs` falls, a command sent while busy, and a reset after the latch has been set.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_WEN   = 3'd5,
    OP_WDS   = 3'd6
  } pcs_op_e;

  function automatic logic is_prog(input pcs_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERAL) || (op == OP_WRAL);
  endfunction
endpackage

// File: rtl/pcs_wel.sv
// Sticky write-enable latch; frozen while a cycle runs.
module pcs_wel
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  pcs_op_e    cmd_op,
  input  logic       busy,
  output logic       wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (cmd_valid && !busy) begin
      if (cmd_op == OP_WEN)      wel <= 1'b1;
      else if (cmd_op == OP_WDS) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/pcs_window.sv
// Arms a program command and fires it only on a CS fall before the next SK rise.
module pcs_window
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  pcs_op_e           cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              busy,
  input  logic              wel,
  input  logic              cs_q,
  input  logic              cs_fall,
  input  logic              sk_rise,
  output logic              start,
  output pcs_op_e           op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic armed;
  logic accept;

  assign accept = cmd_valid && !busy && wel && is_prog(cmd_op);
  assign start  = armed && cs_fall && !sk_rise && wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      armed  <= 1'b1;
      op_q   <= cmd_op;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end else if (armed && (cs_fall || sk_rise || !cs_q)) begin
      armed  <= 1'b0;
    end
  end
endmodule

// File: rtl/pcs_engine.sv
// Self-timed cycle: counts CYCLE_CLKS clocks and sweeps the array write port.
module pcs_engine
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pcs_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(CYCLE_CLKS + 1);
  localparam logic [CW-1:0] LAST    = CW'(CYCLE_CLKS - 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [CW-1:0]     cnt;
  pcs_op_e           op_r;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] data_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_r   <= OP_READ;
      addr_r <= '0;
      data_r <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      op_r   <= op;
      addr_r <= addr;
      data_r <= data;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = addr_r;
    mem_wdata = ONES;
    if (busy) begin
      unique case (op_r)
        OP_WRITE: begin
          if (cnt == '0) begin
            mem_we = 1'b1;
          end else if (cnt == CW'(1)) begin
            mem_we    = 1'b1;
            mem_wdata = data_r;
          end
        end
        OP_ERASE: mem_we = (cnt == '0);
        OP_ERAL, OP_WRAL: begin
          mem_we    = (cnt < DEPTH_C);
          mem_addr  = cnt[ADDR_W-1:0];
          mem_wdata = (op_r == OP_WRAL) ? data_r : ONES;
        end
        default: mem_we = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pcs_status.sv
// Ready/busy status on data out, hidden again by a dummy 1 on DI.
module pcs_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic cs,
  input  logic di,
  input  logic sk_rise,
  input  logic sk_fall,
  output logic do_out,
  output logic do_oe
);
  logic show;
  logic hide_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show      <= 1'b0;
      hide_pend <= 1'b0;
    end else if (start) begin
      show      <= 1'b1;
      hide_pend <= 1'b0;
    end else if (hide_pend && sk_fall) begin
      show      <= 1'b0;
      hide_pend <= 1'b0;
    end else if (show && cs && sk_rise && di) begin
      hide_pend <= 1'b1;
    end
  end

  assign do_oe  = cs && show;
  assign do_out = !busy;
endmodule

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              do_out,
  output logic              do_oe,
  output logic              busy
);
  logic cs_q, sk_q;
  logic cs_fall, sk_rise, sk_fall;
  logic wel, start;
  pcs_op_e           op_in, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign op_in = pcs_op_e'(cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
    end
  end

  assign cs_fall = cs_q && !cs;
  assign sk_rise = !sk_q && sk;
  assign sk_fall = sk_q && !sk;

  pcs_wel u_wel (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_in),
    .busy(busy), .wel(wel)
  );

  pcs_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_win (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_in),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .wel(wel),
    .cs_q(cs_q), .cs_fall(cs_fall), .sk_rise(sk_rise), .start(start),
    .op_q(op_q), .addr_q(addr_q), .data_q(data_q)
  );

  pcs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYCLE_CLKS)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_q), .addr(addr_q),
    .data(data_q), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  pcs_status u_st (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cs(cs), .di(di),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .do_out(do_out), .do_oe(do_oe)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic busy,
  input logic mem_we,
  input logic wel
);
  // R6, R7, R8: the array is written only inside a busy period
  assert_we_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R4: a busy period begins one clock after a CS falling edge
  assert_start_on_cs_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cs) && $past(cs, 2)));

  // R2: no cycle without the enable latch set
  assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R5: a cycle lasts more than one clock
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R11: the latch cannot change during a cycle
  assert_wel_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wel));
endmodule

bind prog_cycle_seq pcs_checker u_pcs_checker (
  .clk(clk), .rst_n(rst_n), .cs(cs), .busy(busy), .mem_we(mem_we), .wel(wel)
);

// File: tb/tb_prog_cycle_seq.sv
module tb_prog_cycle_seq;
  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int CYC = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic mem_we, do_out, do_oe, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  logic [AW+DW-1:0] exp_q[$];

  always #5 clk = ~clk;

  prog_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs), .sk(sk), .di(di),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .do_out(do_out), .do_oe(do_oe), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({a, d});
  endtask

  // Scoreboard monitor: every array write must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected write %0h=%0h expected none", cur_req, mem_addr, mem_wdata);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        if (e != {mem_addr, mem_wdata}) begin
          fails++;
          $display("FAIL %s: write %0h expected %0h", cur_req, {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs = 1'b1;
    tick();
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  // Drop CS and expect either a full busy period or none
  task automatic commit(input bit expect_run, input string req);
    int n;
    cs = 1'b0;
    tick();
    if (expect_run) begin
      n = 0;
      while (busy && n < 4 * CYC) begin n++; tick(); end
      check(n == CYC, req, n, CYC);
    end else begin
      tick(CYC + 4);
      check(busy == 1'b0, req, busy, 0);
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    tick(2);
    check(busy == 0 && do_oe == 0 && mem_we == 0, "R1 in reset", {busy, do_oe, mem_we}, 0);
    rst_n = 1'b1;
    tick();
    check(busy == 0 && do_oe == 0, "R1 after reset", {busy, do_oe}, 0);

    // R2: latch clear, program commands ignored
    cur_req = "R2";
    send(3'd1, 4'd3, 16'h1111); commit(0, "R2 write disabled");
    send(3'd3, 4'd0, 16'h0);    commit(0, "R2 erase all disabled");

    // R3 enable, R6 write with status R9 and release R10
    cur_req = "R6";
    send(3'd5, 4'd0, 16'h0); cs = 1'b0; tick();
    send(3'd1, 4'd3, 16'hA5A5);
    push(4'd3, 16'hFFFF); push(4'd3, 16'hA5A5);
    cs = 1'b0; tick();
    check(busy == 1'b1, "R5 busy after cs fall", busy, 1);
    check(do_oe == 1'b0, "R9 hidden while cs low", do_oe, 0);
    cs = 1'b1;
    n = 1;
    tick();
    check(do_oe == 1'b1 && do_out == 1'b0, "R9 busy status", {do_oe, do_out}, 2'b10);
    while (busy && n < 4 * CYC) begin n++; tick(); end
    check(n == CYC, "R5 cycle length", n, CYC);
    check(do_oe == 1'b1 && do_out == 1'b1, "R9 ready status", {do_oe, do_out}, 2'b11);
    check(exp_q.size() == 0, "R6 both writes seen", exp_q.size(), 0);
    di = 1'b1; sk = 1'b1; tick();
    check(do_oe == 1'b1, "R10 held until sk falls", do_oe, 1);
    sk = 1'b0; di = 1'b0; tick();
    check(do_oe == 1'b0, "R10 released", do_oe, 0);

    // R4: sk rises before cs falls, command dropped
    cur_req = "R4";
    send(3'd2, 4'd5, 16'h0);
    sk = 1'b1; tick(); sk = 1'b0; tick();
    commit(0, "R4 late cs");

    // R7 erase
    cur_req = "R7";
    send(3'd2, 4'd5, 16'h0); push(4'd5, 16'hFFFF);
    commit(1, "R7 erase");

    // R11: commands during busy are dropped
    cur_req = "R11";
    send(3'd1, 4'd1, 16'h1234); push(4'd1, 16'hFFFF); push(4'd1, 16'h1234);
    cs = 1'b0; tick();
    send(3'd6, 4'd0, 16'h0);
    send(3'd1, 4'd9, 16'hBEEF);
    cs = 1'b0;
    n = 0;
    while (busy && n < 4 * CYC) begin n++; tick(); end
    tick(4);
    check(exp_q.size() == 0 && busy == 0, "R11 no extra cycle", exp_q.size(), 0);
    send(3'd1, 4'd2, 16'h00C3); push(4'd2, 16'hFFFF); push(4'd2, 16'h00C3);
    commit(1, "R11 latch kept set R3");

    // R8 write all then erase all
    cur_req = "R8";
    send(3'd4, 4'd7, 16'h0F0F);
    for (int i = 0; i < DEPTH; i++) push(AW'(i), 16'h0F0F);
    commit(1, "R8 write all");
    send(3'd3, 4'd0, 16'h0);
    for (int i = 0; i < DEPTH; i++) push(AW'(i), 16'hFFFF);
    commit(1, "R8 erase all");

    // R12 read does nothing; R3 disable clears latch
    cur_req = "R12";
    send(3'd0, 4'd4, 16'h0); commit(0, "R12 read no cycle");
    cur_req = "R3";
    send(3'd6, 4'd0, 16'h0); cs = 1'b0; tick();
    send(3'd2, 4'd4, 16'h0); commit(0, "R3 disabled erase");

    // R1/R3: reset clears a set latch
    cur_req = "R1";
    send(3'd5, 4'd0, 16'h0); cs = 1'b0; tick();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick();
    send(3'd1, 4'd6, 16'h5555); commit(0, "R1 reset clears latch R3");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule